// File: doc/BRIEF.md
# Asynchronous Handshake Read Link

This block carries one read transfer at a time between a requesting agent and a small memory-like responder. There is no shared strobe or clock that times the transfer: the two sides coordinate only through three control lines and a single set of shared data lines. The requester sends an address on those lines. The responder sends back the stored word on the same lines. Every step waits until the other side has visibly acted before it proceeds, so the transfer is correct for any delay on either side.

The requester is driven from a local start/address interface. It reports `busy` while a transfer is open, and it pulses `done` with the returned word on `rdata`. The responder holds a register array of 2^ADDR_W words, filled at reset with a computed pattern. Each side passes the control lines it receives from the other side through a two-flop synchronizer before its state machine acts on them. Each side also has its own drive enable onto the shared lines, and a resolver merges the two drivers. The control lines, drive enables and the resolved lines are brought out so that the protocol can be observed.

Top module: `async_read_link`

## Requirements
- R1: While `rst_n` is low, `busy`, `done`, `read_req`, `rsp_ack`, `data_rdy`, `req_ack`, `req_drive`, `rsp_drive` and `rdata` are all 0 after the next clock edge.
- R2: A `start` sampled while `busy` is 0 begins a transfer. From the next cycle `busy` is 1, the requester drives `bus_data` with `addr` zero-extended to DATA_W bits, and it raises `read_req`.
- R3: The responder captures the address and raises `rsp_ack` only after it sees `read_req` high. The requester releases the bus and lowers `read_req` only while `rsp_ack` is high.
- R4: The responder lowers `rsp_ack`, drives the word and raises `data_rdy` only after it sees `read_req` low. When `data_rdy` rises, `read_req` and `rsp_ack` are both low.
- R5: The requester captures the word and raises `req_ack` after it sees `data_rdy` high. The responder then releases the bus and lowers `data_rdy`. Once the requester sees `data_rdy` low, it lowers `req_ack`, pulses `done` for exactly one cycle and clears `busy`. `req_ack` falls only while `data_rdy` is low.
- R6: The vector {read_req, rsp_ack, data_rdy, req_ack} only takes the values 0000, 1000, 1100, 0100, 0010, 0011, 0001, in that cyclic order. Each cycle it either holds or moves one step forward.
- R7: `req_drive` and `rsp_drive` are never 1 in the same cycle.
- R8: The word returned for address a, both on `bus_data` while the responder drives and on `rdata` when `done` pulses, is (a*0x1357 + 0x00A5) mod 2^DATA_W.
- R9: A `start` sampled while `busy` is 1 has no effect. The open transfer completes with the word of its own address, and no further transfer follows.
- R10: When neither side drives, `bus_data` is 0.
- R11: A `start` given in the cycle where `done` is high and `busy` has just dropped is accepted, so transfers can run back to back.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for both sides |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request a read of `addr` |
| addr | input | ADDR_W | Word address to read |
| busy | output | 1 | A transfer is in progress |
| done | output | 1 | One-cycle pulse: `rdata` is valid |
| rdata | output | DATA_W | Word returned by the last transfer |
| read_req | output | 1 | Read request line (requester to responder) |
| rsp_ack | output | 1 | Acknowledge line from the responder |
| data_rdy | output | 1 | Data-ready line from the responder |
| req_ack | output | 1 | Acknowledge line from the requester |
| req_drive | output | 1 | Requester enables its driver on the shared lines |
| rsp_drive | output | 1 | Responder enables its driver on the shared lines |
| bus_data | output | DATA_W | Resolved value of the shared lines |

## Verification
The main function is exercised with single isolated reads, with the lowest and highest addresses, and with a back-to-back sweep of every address started in the same cycle that the previous transfer ends. The isolated reads separate the handshake ordering from any effect of one transfer on the next. The back-to-back sweep shows whether a new request can overrun the closing steps of the previous one, and whether every array entry is reached. A start pulse issued in the middle of a transfer shows whether the captured address can be overwritten. A reference model in the bench tracks the legal control sequence, the owner of the shared lines and the expected word every cycle. It catches an out-of-order edge, a driver overlap or a wrong word in the cycle where it appears.

// File: rtl/hs_pkg.sv
// Package: shared state encodings for the two handshake agents.
// Assumes: nothing beyond IEEE 1800-2017 enums.
package hs_pkg;

    // Requester progress through one read transfer.
    typedef enum logic [1:0] {
        RQ_IDLE     = 2'd0,
        RQ_ADDR     = 2'd1,
        RQ_WAITDATA = 2'd2,
        RQ_ACKDATA  = 2'd3
    } req_state_t;

    // Responder progress through one read transfer.
    typedef enum logic [1:0] {
        RS_IDLE    = 2'd0,
        RS_GOTADDR = 2'd1,
        RS_SEND    = 2'd2,
        RS_CLOSE   = 2'd3
    } rsp_state_t;

endpackage

// File: rtl/hs_sync.sv
// Module: multi-stage flop synchronizer for control lines entering a side.
// Assumes: STAGES >= 2; each bit is an independent level signal, so no
// multi-bit coherence is needed.
module hs_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] chain [STAGES];

    // First stage samples the foreign signal.
    always_ff @(posedge clk) begin
        if (!rst_n) chain[0] <= '0;
        else        chain[0] <= d;
    end

    generate
        for (genvar g = 1; g < STAGES; g++) begin : g_stage
            // Each further stage resamples the previous one.
            always_ff @(posedge clk) begin
                if (!rst_n) chain[g] <= '0;
                else        chain[g] <= chain[g-1];
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/hs_requester.sv
// Module: requesting side of the read handshake. It accepts a local start,
// drives the address, waits for the word and closes the handshake.
// Assumes: ack_in and dr_in come from the other side and are synchronized
// here. bus_in is read only while the other side holds it steady.
module hs_requester
    import hs_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 4,
    parameter int STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] addr,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rdata,
    input  logic              ack_in,
    input  logic              dr_in,
    output logic              read_req,
    output logic              req_ack,
    output logic              drive,
    output logic [DATA_W-1:0] drive_data,
    input  logic [DATA_W-1:0] bus_in
);
    localparam int PAD_W = DATA_W - ADDR_W;

    req_state_t        state;
    logic [ADDR_W-1:0] addr_q;
    logic              ack_s;
    logic              dr_s;

    hs_sync #(.WIDTH(2), .STAGES(STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    ({ack_in, dr_in}),
        .q    ({ack_s, dr_s})
    );

    // Step the requester through address, wait, capture and close.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= RQ_IDLE;
            addr_q   <= '0;
            busy     <= 1'b0;
            done     <= 1'b0;
            rdata    <= '0;
            read_req <= 1'b0;
            req_ack  <= 1'b0;
            drive    <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                RQ_IDLE: begin
                    if (start) begin
                        addr_q   <= addr;
                        drive    <= 1'b1;
                        read_req <= 1'b1;
                        busy     <= 1'b1;
                        state    <= RQ_ADDR;
                    end
                end
                RQ_ADDR: begin
                    if (ack_s) begin
                        drive    <= 1'b0;
                        read_req <= 1'b0;
                        state    <= RQ_WAITDATA;
                    end
                end
                RQ_WAITDATA: begin
                    if (dr_s) begin
                        rdata   <= bus_in;
                        req_ack <= 1'b1;
                        state   <= RQ_ACKDATA;
                    end
                end
                RQ_ACKDATA: begin
                    if (!dr_s) begin
                        req_ack <= 1'b0;
                        busy    <= 1'b0;
                        done    <= 1'b1;
                        state   <= RQ_IDLE;
                    end
                end
                default: state <= RQ_IDLE;
            endcase
        end
    end

    // Address zero-extended onto the shared lines.
    assign drive_data = {{PAD_W{1'b0}}, addr_q};

    AST_START_IGNORED_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> (addr_q == $past(addr_q))); // R9
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R5
    AST_RELEASE_ON_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(read_req) |-> ack_s); // R3
    AST_ACK_DROP_ON_DR_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(req_ack) |-> !dr_s); // R5
endmodule

// File: rtl/hs_responder.sv
// Module: responding side, standing in for memory. It captures the address,
// looks it up in a register array filled at reset and returns the word.
// Assumes: rr_in and qack_in come from the other side and are synchronized
// here. An address with nonzero bits above ADDR_W reads as zero.
module hs_responder
    import hs_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 4,
    parameter int STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rr_in,
    input  logic              qack_in,
    output logic              rsp_ack,
    output logic              data_rdy,
    output logic              drive,
    output logic [DATA_W-1:0] drive_data,
    input  logic [DATA_W-1:0] bus_in
);
    localparam int DEPTH = 1 << ADDR_W;

    rsp_state_t        state;
    logic [DATA_W-1:0] addr_q;
    logic [DATA_W-1:0] mem [DEPTH];
    logic              rr_s;
    logic              qack_s;

    // Seed pattern for array entry i.
    function automatic logic [DATA_W-1:0] seed_word(input int i);
        return DATA_W'(i * 32'h1357 + 32'h00A5);
    endfunction

    hs_sync #(.WIDTH(2), .STAGES(STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    ({rr_in, qack_in}),
        .q    ({rr_s, qack_s})
    );

    // Fill the register array at reset, and hold it afterwards.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= seed_word(i);
        end
    end

    // Step the responder through capture, return and close.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= RS_IDLE;
            addr_q     <= '0;
            rsp_ack    <= 1'b0;
            data_rdy   <= 1'b0;
            drive      <= 1'b0;
            drive_data <= '0;
        end else begin
            case (state)
                RS_IDLE: begin
                    if (rr_s) begin
                        addr_q  <= bus_in;
                        rsp_ack <= 1'b1;
                        state   <= RS_GOTADDR;
                    end
                end
                RS_GOTADDR: begin
                    if (!rr_s) begin
                        rsp_ack    <= 1'b0;
                        drive_data <= (addr_q[DATA_W-1:ADDR_W] == '0) ?
                                      mem[addr_q[ADDR_W-1:0]] : '0;
                        drive      <= 1'b1;
                        data_rdy   <= 1'b1;
                        state      <= RS_SEND;
                    end
                end
                RS_SEND: begin
                    if (qack_s) begin
                        drive    <= 1'b0;
                        data_rdy <= 1'b0;
                        state    <= RS_CLOSE;
                    end
                end
                RS_CLOSE: begin
                    if (!qack_s) state <= RS_IDLE;
                end
                default: state <= RS_IDLE;
            endcase
        end
    end

    AST_DR_AFTER_REQ_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(data_rdy) |-> !rr_s); // R4
    AST_ACK_HELD_WHILE_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_ack && rr_s) |=> rsp_ack); // R3
    AST_ACK_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rsp_ack) |-> rr_s); // R3
endmodule

// File: rtl/hs_bus_resolver.sv
// Module: merges the two enabled drivers into the value seen on the shared
// lines. An undriven bus reads as zero.
// Assumes: at most one enable is high; the top-level check guards this.
module hs_bus_resolver #(
    parameter int DATA_W = 16
) (
    input  logic              en_a,
    input  logic [DATA_W-1:0] data_a,
    input  logic              en_b,
    input  logic [DATA_W-1:0] data_b,
    output logic [DATA_W-1:0] bus
);
    // OR of the gated drivers, as a wired bus would settle.
    always_comb begin
        bus = (en_a ? data_a : '0) | (en_b ? data_b : '0);
    end
endmodule

// File: rtl/async_read_link.sv
// Module: top level of the handshake read link. It connects the requester,
// the responder and the bus resolver, and brings the protocol lines out.
// Assumes: DATA_W > ADDR_W; both sides share clk here, but neither relies
// on that, because every control crossing is synchronized.
module async_read_link #(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 4,
    parameter int STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] addr,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rdata,
    output logic              read_req,
    output logic              rsp_ack,
    output logic              data_rdy,
    output logic              req_ack,
    output logic              req_drive,
    output logic              rsp_drive,
    output logic [DATA_W-1:0] bus_data
);
    logic [DATA_W-1:0] req_out;
    logic [DATA_W-1:0] rsp_out;

    hs_requester #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .STAGES(STAGES)) u_req (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .addr      (addr),
        .busy      (busy),
        .done      (done),
        .rdata     (rdata),
        .ack_in    (rsp_ack),
        .dr_in     (data_rdy),
        .read_req  (read_req),
        .req_ack   (req_ack),
        .drive     (req_drive),
        .drive_data(req_out),
        .bus_in    (bus_data)
    );

    hs_responder #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .STAGES(STAGES)) u_rsp (
        .clk       (clk),
        .rst_n     (rst_n),
        .rr_in     (read_req),
        .qack_in   (req_ack),
        .rsp_ack   (rsp_ack),
        .data_rdy  (data_rdy),
        .drive     (rsp_drive),
        .drive_data(rsp_out),
        .bus_in    (bus_data)
    );

    hs_bus_resolver #(.DATA_W(DATA_W)) u_bus (
        .en_a  (req_drive),
        .data_a(req_out),
        .en_b  (rsp_drive),
        .data_b(rsp_out),
        .bus   (bus_data)
    );

    AST_ONE_DRIVER: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_drive && rsp_drive)); // R7
endmodule

// File: tb/async_read_link_tb.sv
// Bench: drives reads through the local interface and tracks a behavioural
// model of the control sequence, bus owner and expected word every clock.
module async_read_link_tb;
    localparam int DW = 16;
    localparam int AW = 4;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          start;
    logic [AW-1:0] addr;
    logic          busy, done, read_req, rsp_ack, data_rdy, req_ack;
    logic          req_drive, rsp_drive;
    logic [DW-1:0] rdata, bus_data;

    always #10 clk = ~clk;

    async_read_link #(.DATA_W(DW), .ADDR_W(AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .addr(addr),
        .busy(busy), .done(done), .rdata(rdata),
        .read_req(read_req), .rsp_ack(rsp_ack), .data_rdy(data_rdy),
        .req_ack(req_ack), .req_drive(req_drive), .rsp_drive(rsp_drive),
        .bus_data(bus_data)
    );

    int   n_run = 0;
    int   n_fail = 0;
    int   cyc = 0;
    int   dones = 0;
    int   issued = 0;
    int   prev_idx = 0;
    bit   finished = 1'b0;
    int   exp_q[$];
    logic [3:0] v_now;
    logic [3:0] v_prev = 4'b0000;
    int   legal [7] = '{4'b0000, 4'b1000, 4'b1100, 4'b0100,
                        4'b0010, 4'b0011, 4'b0001};

    function automatic logic [DW-1:0] word_of(input int a);
        return DW'(a * 'h1357 + 'hA5);
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    // Reference model: legal control order, bus owner and word, every clock.
    always @(negedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            check(1'b0, "WATCHDOG", "run did not end", cyc, 150000);
            finish_run();
        end
        if (rst_n && !finished) begin
            int idx;
            v_now = {read_req, rsp_ack, data_rdy, req_ack};
            idx = -1;
            for (int k = 0; k < 7; k++) if (legal[k] == int'(v_now)) idx = k;
            check(idx >= 0 && (idx == prev_idx || idx == (prev_idx + 1) % 7),
                  "R6", "control vector order", v_now, legal[(prev_idx+1)%7]);
            if (idx >= 0) prev_idx = idx;
            if (v_prev[3] && !v_now[3])
                check(v_now[2], "R3", "rsp_ack at read_req fall", v_now[2], 1);
            if (!v_prev[1] && v_now[1])
                check(!v_now[3] && !v_now[2], "R4", "req/ack low at data_rdy rise",
                      v_now, 4'b0010);
            if (v_prev[0] && !v_now[0])
                check(!v_now[1], "R5", "data_rdy low at req_ack fall", v_now[1], 0);
            check(!(req_drive && rsp_drive), "R7", "driver overlap",
                  {req_drive, rsp_drive}, 0);
            if (req_drive)
                check(exp_q.size() > 0 && bus_data == DW'(exp_q[0]), "R2",
                      "address on bus", bus_data,
                      exp_q.size() > 0 ? exp_q[0] : -1);
            if (rsp_drive)
                check(exp_q.size() > 0 && bus_data == word_of(exp_q[0]), "R8",
                      "word on bus", bus_data,
                      exp_q.size() > 0 ? word_of(exp_q[0]) : 0);
            if (!req_drive && !rsp_drive)
                check(bus_data == '0, "R10", "idle bus", bus_data, 0);
            if (done) begin
                check(exp_q.size() > 0 && rdata == word_of(exp_q[0]), "R8",
                      "rdata at done", rdata,
                      exp_q.size() > 0 ? word_of(exp_q[0]) : 0);
                check(!busy, "R5", "busy cleared with done", busy, 0);
                if (exp_q.size() > 0) void'(exp_q.pop_front());
                dones++;
            end
            v_prev = v_now;
        end
    end

    task automatic issue(input int a, input string tag);
        while (busy) @(negedge clk);
        addr  = AW'(a);
        start = 1'b1;
        exp_q.push_back(a);
        issued++;
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b1, tag, "busy after accepted start", busy, 1);
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        rst_n = 1'b0;
        start = 1'b0;
        addr  = '0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(!busy && !done, "R1", "busy/done in reset", {busy, done}, 0);
        check({read_req, rsp_ack, data_rdy, req_ack} == 4'b0, "R1",
              "control lines in reset", {read_req, rsp_ack, data_rdy, req_ack}, 0);
        check(!req_drive && !rsp_drive, "R1", "drivers in reset",
              {req_drive, rsp_drive}, 0);
        check(rdata == '0, "R1", "rdata in reset", rdata, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Isolated reads, including the lowest and highest address (R2, R8)
        issue(5, "R2");
        wait_idle();
        check(rdata == word_of(5), "R8", "word for 5", rdata, word_of(5));
        issue(0, "R2");
        wait_idle();
        issue(15, "R2");
        wait_idle();
        check(rdata == word_of(15), "R8", "word for 15", rdata, word_of(15));

        // Start during an open transfer is ignored (R9)
        issue(3, "R2");
        repeat (4) @(negedge clk);
        addr  = AW'(9);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b1, "R9", "still busy after ignored start", busy, 1);
        wait_idle();
        check(rdata == word_of(3), "R9", "word of original address", rdata, word_of(3));
        repeat (12) @(negedge clk);
        check(!busy && !read_req, "R9", "no transfer after ignored start",
              {busy, read_req}, 0);

        // Back-to-back sweep of every address (R11)
        for (int a = 0; a < (1 << AW); a++) issue(a, "R11");
        wait_idle();
        check(exp_q.size() == 0, "R5", "all transfers completed", exp_q.size(), 0);
        check(dones == issued, "R5", "done count", dones, issued);

        finish_run();
    end
endmodule